// File: doc/BRIEF.md
# Frame-Gated Parallel Input Serializer

This block lets a host controller read eleven extra input pins over three wires. The host pulls the active-low frame-select line low, and the block takes one snapshot of all eleven pins. The host then toggles a serial clock, and the block shifts the snapshot out one bit per falling clock edge, starting with bit 0. The host sees bit 0 before it sends any clock edge.

Everything runs on one system clock. The frame-select and serial-clock inputs are asynchronous to that clock. Each goes through a synchronizer chain, and its edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock.

The serial output is a data bit plus a drive flag that stands in for a tri-state buffer. The drive flag is deasserted whenever the frame-select line is high. If the host sends more clock edges than there are pins, the output is forced to 0 and an active-low valid flag is raised.

Top module: `snap_serial_expander`

## Requirements
- R1: While reset is applied and in the cycle after it, `serOutEn`, `serOut` and `dataValidN` are all 0.
- R2: When `selN` goes from 1 to 0, all pins are captured together. Within three system clock cycles `serOutEn` is 1 and `serOut` carries pin bit 0, with no serial clock edge needed.
- R3: While `selN` is 0, each 1-to-0 transition of `shiftClk` advances `serOut` to the next pin. Pins come out in increasing index order, bit 1 through bit 10, and each new bit appears within three system clock cycles.
- R4: A 0-to-1 transition of `shiftClk` leaves `serOut` unchanged.
- R5: Within three system clock cycles of `selN` going high, `serOutEn` is 0 and `serOut` is 0. Serial clock edges that arrive while `selN` is high change nothing.
- R6: The 11th falling `shiftClk` edge of a frame, and every later one, gives `serOut` = 0 and `dataValidN` = 1. Both stay that way until the next capture or reset.
- R7: Changes on `pinsIn` after the capture do not alter the bits shifted out in that frame.
- R8: A new capture clears `dataValidN` to 0, even after an overrun.
- R9: A synchronous reset asserted mid-frame returns the outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pinsIn | input | NUM_BITS (11) | Parallel pins to be read; bit 0 is sent first |
| selN | input | 1 | Asynchronous active-low frame select |
| shiftClk | input | 1 | Asynchronous serial clock; falling edges advance the output |
| serOut | output | 1 | Serial data bit |
| serOutEn | output | 1 | 1 = serial output driven, 0 = high impedance |
| dataValidN | output | 1 | 1 = frame overrun, the current bit is invalid |

## Verification
The bench builds the block with its defaults: eleven pins and a two-stage synchronizer. With eleven pins the overrun boundary is reached on the 11th falling clock edge, so the bench can drive past it with a few extra edges. With two synchronizer stages, every output change lands exactly three system cycles after the input edge that causes it. This fixed latency lets the bench model predict each output value cycle by cycle. It also lets the bench place serial clock edges while the frame select is high, and a reset inside a frame, at known points.

// File: rtl/snapser_pkg.sv
package snapser_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic load;   // take a snapshot of the pins and restart the bit count
    logic shift;  // move on to the next bit
    logic drive;  // serial output is driven (not high impedance)
  } snapStrobe_t;

endpackage

// File: rtl/snapser_sync_edge.sv
module snapser_sync_edge #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic levelOut,
  output logic fallPulse
);

  logic [STAGES-1:0] chain;
  logic              lastLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain     <= {STAGES{RESET_VAL}};
      lastLevel <= RESET_VAL;
    end else begin
      chain     <= {chain[STAGES-2:0], asyncIn};
      lastLevel <= chain[STAGES-1];
    end
  end

  assign levelOut  = chain[STAGES-1];
  assign fallPulse = lastLevel & ~chain[STAGES-1];

endmodule

// File: rtl/snapser_ctrl.sv
module snapser_ctrl
  import snapser_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enLevel,   // synchronized frame select (active low)
  input  logic        enFall,    // start of frame
  input  logic        clkFall,   // falling serial clock edge
  output snapStrobe_t strobe
);

  logic driveQ;

  always_ff @(posedge clk) begin
    if (rst) driveQ <= 1'b0;
    else     driveQ <= ~enLevel;
  end

  always_comb begin
    strobe.load  = enFall;
    // A capture takes priority; clock edges outside a frame are ignored.
    strobe.shift = clkFall & ~enLevel & ~enFall;
    strobe.drive = driveQ;
  end

  p_drive_off_r5: assert property (@(posedge clk) disable iff (rst)
    enLevel |=> !strobe.drive);

  p_drive_on_capture_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> strobe.drive);

endmodule

// File: rtl/snapser_dpath.sv
module snapser_dpath
  import snapser_pkg::*;
#(
  parameter int NUM_BITS = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  snapStrobe_t         strobe,
  input  logic [NUM_BITS-1:0] pinsIn,
  output logic                serData,
  output logic                overrun
);

  localparam int CNT_W = $clog2(NUM_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BITS - 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(NUM_BITS);

  logic [NUM_BITS-1:0] shReg;
  logic [CNT_W-1:0]    bitCnt;
  logic                overQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg  <= '0;
      bitCnt <= '0;
      overQ  <= 1'b0;
    end else if (strobe.load) begin
      shReg  <= pinsIn;
      bitCnt <= '0;
      overQ  <= 1'b0;
    end else if (strobe.shift) begin
      if (bitCnt < LAST) begin
        shReg  <= {1'b0, shReg[NUM_BITS-1:1]};
        bitCnt <= bitCnt + CNT_W'(1);
      end else begin
        bitCnt <= DONE;
        overQ  <= 1'b1;
      end
    end
  end

  assign serData = strobe.drive & ~overQ & shReg[0];
  assign overrun = overQ;

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (shReg == $past(pinsIn)) && (bitCnt == '0) && !overQ);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.shift) |=> $stable(shReg) && $stable(bitCnt));

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && bitCnt >= LAST) |=> overQ);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= DONE);

endmodule

// File: rtl/snap_serial_expander.sv
module snap_serial_expander
  import snapser_pkg::*;
#(
  parameter int NUM_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] pinsIn,
  input  logic                selN,
  input  logic                shiftClk,
  output logic                serOut,
  output logic                serOutEn,
  output logic                dataValidN
);

  logic        enLevel, enFall;
  logic        sclkLevel, sclkFall;
  logic        overrun;
  snapStrobe_t strobe;

  snapser_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_selSync (
    .clk(clk), .rst(rst), .asyncIn(selN),
    .levelOut(enLevel), .fallPulse(enFall)
  );

  snapser_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_clkSync (
    .clk(clk), .rst(rst), .asyncIn(shiftClk),
    .levelOut(sclkLevel), .fallPulse(sclkFall)
  );

  snapser_ctrl u_ctrl (
    .clk(clk), .rst(rst), .enLevel(enLevel), .enFall(enFall),
    .clkFall(sclkFall), .strobe(strobe)
  );

  snapser_dpath #(.NUM_BITS(NUM_BITS)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .pinsIn(pinsIn),
    .serData(serOut), .overrun(overrun)
  );

  assign serOutEn   = strobe.drive;
  assign dataValidN = overrun;

  p_overrun_zero_r6: assert property (@(posedge clk) disable iff (rst)
    dataValidN |-> !serOut);

  p_rise_no_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (sclkLevel && !enFall) |=> $stable(dataValidN));

endmodule

// File: tb/snap_serial_expander_tb.sv
module snap_serial_expander_tb;

  localparam int NB   = 11;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          selN = 1'b1;
  logic          sclk = 1'b1;
  logic [NB-1:0] pins = '0;
  logic          serOut, serOutEn, dataValidN;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string curReq = "R1";

  // Reference model state
  bit            enQ[$];
  bit            ckQ[$];
  logic [NB-1:0] mCap  = '0;
  int            mIdx  = 0;
  bit            mDrive = 1'b0;
  bit            eFall, cFall, eLow;
  logic          expOut;

  always #5 clk = ~clk;

  snap_serial_expander #(.NUM_BITS(NB), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .pinsIn(pins), .selN(selN), .shiftClk(sclk),
    .serOut(serOut), .serOutEn(serOutEn), .dataValidN(dataValidN)
  );

  function automatic void chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
    end
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      enQ.delete();
      ckQ.delete();
      for (int i = 0; i <= SYNC; i++) begin
        enQ.push_back(1'b1);
        ckQ.push_back(1'b1);
      end
      mCap   = '0;
      mIdx   = 0;
      mDrive = 1'b0;
    end else begin
      eFall = enQ[SYNC] && !enQ[SYNC-1];
      cFall = ckQ[SYNC] && !ckQ[SYNC-1];
      eLow  = !enQ[SYNC-1];
      if (eFall) begin
        mCap = pins;
        mIdx = 0;
      end else if (cFall && eLow && mIdx < NB) begin
        mIdx++;
      end
      mDrive = eLow;
      enQ.push_front(selN);
      ckQ.push_front(sclk);
      void'(enQ.pop_back());
      void'(ckQ.pop_back());
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog (R1..R9 incomplete): actual timeout expected finish");
      summary();
    end
  end

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (cyc >= 1) begin
      expOut = (mDrive && mIdx < NB) ? mCap[mIdx] : 1'b0;
      chk(curReq, "serOut",     serOut,     expOut);
      chk(curReq, "serOutEn",   serOutEn,   mDrive);
      chk(curReq, "dataValidN", dataValidN, (mIdx >= NB) ? 1'b1 : 1'b0);
    end
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkFallEdge();
    sclk = 1'b0;
    ticks(4);
  endtask

  task automatic clkRiseEdge();
    sclk = 1'b1;
    ticks(4);
  endtask

  task automatic runFrame(input logic [NB-1:0] v, input bit scramble, input int extra);
    pins = v;
    ticks(1);
    curReq = "R2";
    selN = 1'b0;
    ticks(4);
    chk("R2", "bit0 before clocks", serOut, v[0]);
    chk("R2", "drive on",           serOutEn, 1'b1);
    chk("R8", "valid after capture", dataValidN, 1'b0);
    if (scramble) pins = ~v;
    for (int i = 1; i < NB; i++) begin
      curReq = scramble ? "R7" : "R3";
      clkFallEdge();
      chk(curReq, "shifted bit", serOut, v[i]);
      curReq = "R4";
      clkRiseEdge();
      chk("R4", "bit held on rise", serOut, v[i]);
    end
    curReq = "R6";
    for (int j = 0; j < extra; j++) begin
      clkFallEdge();
      chk("R6", "overrun data", serOut, 1'b0);
      chk("R6", "overrun flag", dataValidN, 1'b1);
      clkRiseEdge();
    end
    curReq = "R5";
    selN = 1'b1;
    ticks(4);
    chk("R5", "drive off", serOutEn, 1'b0);
    chk("R5", "data low",  serOut, 1'b0);
  endtask

  initial begin
    curReq = "R1";
    ticks(5);
    chk("R1", "reset drive", serOutEn, 1'b0);
    chk("R1", "reset flag",  dataValidN, 1'b0);
    rst = 1'b0;
    ticks(1);
    chk("R1", "post-reset data", serOut, 1'b0);
    ticks(4);

    runFrame(11'h5A3, 1'b0, 3);

    // clock edges while deselected must change nothing
    curReq = "R5";
    for (int k = 0; k < 4; k++) begin
      clkFallEdge();
      chk("R5", "idle drive", serOutEn, 1'b0);
      clkRiseEdge();
    end
    chk("R6", "flag held while idle", dataValidN, 1'b1);

    runFrame(11'h2DE, 1'b1, 0);
    runFrame(11'h7FF, 1'b0, 1);
    runFrame(11'h001, 1'b1, 2);
    runFrame(11'h400, 1'b0, 0);

    // reset in the middle of an overrun frame
    pins = 11'h155;
    ticks(1);
    curReq = "R2";
    selN = 1'b0;
    ticks(4);
    for (int i = 0; i < NB + 1; i++) begin
      curReq = "R6";
      clkFallEdge();
      clkRiseEdge();
    end
    chk("R6", "flag before reset", dataValidN, 1'b1);
    curReq = "R9";
    rst = 1'b1;
    ticks(2);
    chk("R9", "drive cleared", serOutEn, 1'b0);
    chk("R9", "flag cleared",  dataValidN, 1'b0);
    chk("R9", "data cleared",  serOut, 1'b0);
    selN = 1'b1;
    ticks(2);
    rst = 1'b0;
    ticks(6);
    chk("R9", "idle after reset", serOutEn, 1'b0);

    runFrame(11'h0F0, 1'b0, 2);
    ticks(10);
    summary();
  end

endmodule